// File: doc/BRIEF.md
# Text and Planar Pixel Attribute Pipeline

This block sits between the display memory readout and the colour converter of a display adapter. Its job is to produce one 6-bit palette code on every dot clock. In character mode, a shift/load strobe arrives once per character cell. The strobe captures a glyph row byte and a colour attribute byte. The block then emits the glyph dots one per clock. Each dot picks either the foreground or the background nibble of the attribute. In planar graphics mode, the same attribute lines carry a fresh 4-bit colour index on every clock.

Both paths meet at a common index stage. That stage applies the colour plane enable mask, then the graphics blink rule, then a 16-entry palette lookup, and registers the result. A vertical-sync driven counter sets the blink phase. A simple write port loads the palette, the mode bits and the plane mask. The block can draw a 9-dot cell: the last column is filled from the glyph only for line-drawing characters. A cursor or underline input forces foreground and is never blanked by blink.

Top module: `attr_pixel_pipe`

## Requirements
- R1: While reset is asserted and after its release, `pix_out` is 0. All sixteen palette entries, all mode bits and the plane mask are cleared, so every pixel stays 0 until software programs the block.
- R2: A write with `reg_addr` 0..15 loads `reg_wdata` into that palette entry. Address 16 holds the mode bits: bit 0 selects graphics, bit 2 selects 9-dot cells, bit 3 enables blink. Address 17 holds the 4-bit plane mask in `reg_wdata[3:0]`. A write sampled at clock edge n affects the pixel that leaves at edge n+1.
- R3: In character mode, a `load_strobe` sampled at edge n captures `glyph_in`, `attr_in`, `line_gfx` and `cursor_in`. Dot k of that cell is sent most significant glyph bit first and appears on `pix_out` after edge n+k+1.
- R4: A glyph dot of 1 selects `attr[3:0]` as the index. A 0 selects `attr[7:4]`. When blink is enabled, the background index is `{0, attr[6:4]}`.
- R5: In 9-dot mode, dot 8 repeats glyph bit 0 as foreground if `line_gfx` was high at the strobe. Otherwise dot 8 is background. In 8-dot mode each cell has 8 dots.
- R6: When `cursor_in` is high at the strobe, every dot of the cell is foreground, in either blink phase.
- R7: With blink enabled and attribute bit 7 set, the cell's glyph dots show as background during the off phase. They show normally during the on phase.
- R8: In graphics mode, `attr_in[3:0]` sampled at edge n is the index of the pixel that appears after edge n+1. `load_strobe` has no effect in this mode.
- R9: In graphics mode with blink enabled, during the off phase, a masked index with bit 3 set is shown with bit 3 cleared (12 shows as 4). Indices with bit 3 clear are unaffected.
- R10: The index is ANDed with the plane mask before the graphics blink rule and before the palette lookup, in both modes.
- R11: A 5-bit counter advances on each rising edge of `vsync` as sampled by the clock. The off phase is the counter's top bit, so the phase flips every 16 rising edges, starting in the on phase after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 5 | Register address (0..15 palette, 16 mode, 17 plane mask) |
| reg_wdata | input | 6 | Register write data |
| load_strobe | input | 1 | Character-cell shift/load strobe |
| glyph_in | input | 8 | Glyph row dots, leftmost dot in bit 7 |
| attr_in | input | 8 | Attribute byte; low four bits carry the pixel index in graphics mode |
| line_gfx | input | 1 | Current character is a line-drawing character |
| cursor_in | input | 1 | Cursor or underline active for this cell |
| vsync | input | 1 | Vertical sync, drives the blink counter |
| pix_out | output | 6 | Registered palette output |

## Verification
A character strobe driven before edge n produces dot k after edge n+k+1. A graphics index sampled at edge n appears after edge n+1. A palette write sampled at edge n shows on the pixel after edge n+1, so the old value is still visible one half-cycle after the write edge. The bench drives every input on the falling edge and samples on a later falling edge. For character cells it checks dot k on the k+1-th falling edge after the strobe. For graphics streams it holds a two-stage queue of expected values, so each comparison lands on the cycle where that pixel is registered. Each vsync pulse completes before any pixel is checked, so the blink phase is fixed while a pixel is in flight.

// File: rtl/attr_pipe_pkg.sv
package attr_pipe_pkg;
  localparam int IDX_W   = 4;
  localparam int PAL_W   = 6;
  localparam int GLYPH_W = 8;
  localparam int ATTR_W  = 8;
  localparam int ADDR_W  = 5;
  localparam int BLINK_W = 5;
  localparam int DOT_W   = 4;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 5'h10;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 5'h11;

  localparam int MODE_GFX_BIT   = 0;
  localparam int MODE_NINE_BIT  = 2;
  localparam int MODE_BLINK_BIT = 3;

  typedef struct packed {
    logic blink_en;
    logic nine_dot;
    logic gfx;
  } mode_t;

  // Character-mode colour index from the attribute and the dot decision.
  function automatic logic [IDX_W-1:0] text_index(input logic [ATTR_W-1:0] attr,
                                                  input logic fg,
                                                  input logic blink_en);
    if (fg) return attr[IDX_W-1:0];
    return {attr[ATTR_W-1] & ~blink_en, attr[ATTR_W-2:IDX_W]};
  endfunction

  // Graphics blink: the top index bit is dropped during the off phase.
  function automatic logic [IDX_W-1:0] gfx_blink(input logic [IDX_W-1:0] idx,
                                                 input logic dim);
    return {idx[IDX_W-1] & ~dim, idx[IDX_W-2:0]};
  endfunction
endpackage

// File: rtl/attr_regs.sv
module attr_regs
  import attr_pipe_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int PW = PAL_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [PW-1:0] wdata,
  input  logic [IW-1:0] rd_idx,
  output logic [PW-1:0] rd_data,
  output mode_t         mode,
  output logic [IW-1:0] plane_mask
);
  localparam int N = 1 << IW;

  logic [PW-1:0] pal_q [N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_pal
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       pal_q[i] <= '0;
        else if (we && addr == AW'(i))    pal_q[i] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= '0;
      plane_mask <= '0;
    end else if (we) begin
      if (addr == ADDR_MODE) begin
        mode.gfx      <= wdata[MODE_GFX_BIT];
        mode.nine_dot <= wdata[MODE_NINE_BIT];
        mode.blink_en <= wdata[MODE_BLINK_BIT];
      end
      if (addr == ADDR_MASK) plane_mask <= wdata[IW-1:0];
    end
  end

  assign rd_data = pal_q[rd_idx];
endmodule

// File: rtl/attr_blink_timer.sv
module attr_blink_timer
  import attr_pipe_pkg::*;
#(
  parameter int BW = BLINK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vsync,
  output logic          vs_rise,
  output logic [BW-1:0] blink_cnt,
  output logic          blink_off
);
  logic vs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q      <= 1'b0;
      blink_cnt <= '0;
    end else begin
      vs_q <= vsync;
      if (vs_rise) blink_cnt <= blink_cnt + 1'b1;
    end
  end

  assign vs_rise   = vsync & ~vs_q;
  assign blink_off = blink_cnt[BW-1];
endmodule

// File: rtl/attr_serializer.sv
module attr_serializer
  import attr_pipe_pkg::*;
#(
  parameter int GW = GLYPH_W,
  parameter int AW = ATTR_W,
  parameter int DW = DOT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [GW-1:0] glyph,
  input  logic [AW-1:0] attr,
  input  logic          line_gfx,
  input  logic          cursor,
  input  logic          nine_dot,
  input  logic          blink_en,
  input  logic          blink_off,
  output logic [AW-1:0] attr_q,
  output logic [DW-1:0] dot_idx,
  output logic          fg_sel
);
  localparam int SW = $clog2(GW);

  logic [GW-1:0] glyph_q;
  logic [GW-1:0] glyph_rev;
  logic          lg_q;
  logic          cur_q;
  logic          dot_bit;
  logic          blank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glyph_q <= '0;
      attr_q  <= '0;
      lg_q    <= 1'b0;
      cur_q   <= 1'b0;
      dot_idx <= '1;
    end else if (load) begin
      glyph_q <= glyph;
      attr_q  <= attr;
      lg_q    <= line_gfx;
      cur_q   <= cursor;
      dot_idx <= '0;
    end else if (dot_idx != '1) begin
      dot_idx <= dot_idx + 1'b1;
    end
  end

  // Leftmost dot first: reverse so the dot counter indexes directly.
  generate
    for (genvar b = 0; b < GW; b++) begin : g_rev
      assign glyph_rev[b] = glyph_q[GW-1-b];
    end
  endgenerate

  always_comb begin
    if (dot_idx < DW'(GW))       dot_bit = glyph_rev[dot_idx[SW-1:0]];
    else if (dot_idx == DW'(GW)) dot_bit = nine_dot & lg_q & glyph_q[0];
    else                         dot_bit = 1'b0;
  end

  assign blank  = blink_en & attr_q[AW-1] & blink_off;
  assign fg_sel = (dot_bit & ~blank) | cur_q;
endmodule

// File: rtl/attr_pixel_pipe.sv
module attr_pixel_pipe
  import attr_pipe_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [PAL_W-1:0]   reg_wdata,
  input  logic               load_strobe,
  input  logic [GLYPH_W-1:0] glyph_in,
  input  logic [ATTR_W-1:0]  attr_in,
  input  logic               line_gfx,
  input  logic               cursor_in,
  input  logic               vsync,
  output logic [PAL_W-1:0]   pix_out
);
  mode_t               mode;
  logic [IDX_W-1:0]    plane_mask;
  logic [PAL_W-1:0]    pal_data;
  logic                vs_rise;
  logic [BLINK_W-1:0]  blink_cnt;
  logic                blink_off;
  logic [ATTR_W-1:0]   attr_q;
  logic [DOT_W-1:0]    dot_idx;
  logic                fg_sel;
  logic [IDX_W-1:0]    gfx_pix_q;
  logic [IDX_W-1:0]    idx_raw;
  logic [IDX_W-1:0]    idx_masked;
  logic [IDX_W-1:0]    idx_final;
  logic                text_load;

  attr_regs #(.IW(IDX_W), .PW(PAL_W), .AW(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rd_idx     (idx_final),
    .rd_data    (pal_data),
    .mode       (mode),
    .plane_mask (plane_mask)
  );

  attr_blink_timer #(.BW(BLINK_W)) u_blink (
    .clk       (clk),
    .rst_n     (rst_n),
    .vsync     (vsync),
    .vs_rise   (vs_rise),
    .blink_cnt (blink_cnt),
    .blink_off (blink_off)
  );

  assign text_load = load_strobe & ~mode.gfx;

  attr_serializer #(.GW(GLYPH_W), .AW(ATTR_W), .DW(DOT_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (text_load),
    .glyph     (glyph_in),
    .attr      (attr_in),
    .line_gfx  (line_gfx),
    .cursor    (cursor_in),
    .nine_dot  (mode.nine_dot),
    .blink_en  (mode.blink_en),
    .blink_off (blink_off),
    .attr_q    (attr_q),
    .dot_idx   (dot_idx),
    .fg_sel    (fg_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gfx_pix_q <= '0;
    else        gfx_pix_q <= attr_in[IDX_W-1:0];
  end

  assign idx_raw    = mode.gfx ? gfx_pix_q : text_index(attr_q, fg_sel, mode.blink_en);
  assign idx_masked = idx_raw & plane_mask;
  assign idx_final  = mode.gfx ? gfx_blink(idx_masked, mode.blink_en & blink_off)
                               : idx_masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_out <= '0;
    else        pix_out <= pal_data;
  end
endmodule

// File: rtl/attr_pipe_chk.sv
module attr_pipe_chk
  import attr_pipe_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               load_strobe,
  input logic               gfx,
  input logic               blink_en,
  input logic               blink_off,
  input logic               fg_sel,
  input logic [DOT_W-1:0]   dot_idx,
  input logic               vs_rise,
  input logic [BLINK_W-1:0] blink_cnt,
  input logic [IDX_W-1:0]   idx_raw,
  input logic [IDX_W-1:0]   idx_final,
  input logic [IDX_W-1:0]   plane_mask
);
  // R3: a character strobe restarts the dot sequence
  p_load_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_strobe && !gfx) |=> dot_idx == '0);

  // R3: without a strobe the dot position steps by one until it saturates
  p_dot_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_strobe && dot_idx != '1) |=> dot_idx == DOT_W'($past(dot_idx) + 1'b1));

  // R4: with blink on, a background index never carries the top bit
  p_bg_top_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gfx && blink_en && !fg_sel) |-> !idx_raw[IDX_W-1]);

  // R9: during the off phase a graphics index leaves without its top bit
  p_gfx_dim_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gfx && blink_en && blink_off) |-> !idx_final[IDX_W-1]);

  // R10: no disabled plane reaches the palette
  p_plane_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_final & ~plane_mask) == '0);

  // R11: blink counter holds between vsync rising edges
  p_blink_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> $stable(blink_cnt));

  // R11: blink counter advances once per vsync rising edge
  p_blink_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> blink_cnt == BLINK_W'($past(blink_cnt) + 1'b1));
endmodule

bind attr_pixel_pipe attr_pipe_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_strobe (load_strobe),
  .gfx         (mode.gfx),
  .blink_en    (mode.blink_en),
  .blink_off   (blink_off),
  .fg_sel      (fg_sel),
  .dot_idx     (dot_idx),
  .vs_rise     (vs_rise),
  .blink_cnt   (blink_cnt),
  .idx_raw     (idx_raw),
  .idx_final   (idx_final),
  .plane_mask  (plane_mask)
);

// File: tb/attr_pixel_pipe_tb.sv
module attr_pixel_pipe_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [4:0] reg_addr;
  logic [5:0] reg_wdata;
  logic       load_strobe;
  logic [7:0] glyph_in;
  logic [7:0] attr_in;
  logic       line_gfx;
  logic       cursor_in;
  logic       vsync;
  logic [5:0] pix_out;

  always #10 clk = ~clk;

  attr_pixel_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .load_strobe(load_strobe), .glyph_in(glyph_in),
    .attr_in(attr_in), .line_gfx(line_gfx), .cursor_in(cursor_in),
    .vsync(vsync), .pix_out(pix_out)
  );

  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 0;
  logic [5:0] b_pal [16];
  logic b_gfx = 0, b_nine = 0, b_blink = 0;
  logic [3:0] b_mask = 4'h0;
  int   b_vs = 0;

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: pix_out=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit off_phase();
    return (b_vs % 32) >= 16;
  endfunction

  function automatic logic [5:0] exp_text(input logic [7:0] g, input logic [7:0] a,
                                          input logic lg, input logic cur, input int k);
    logic       lit;
    logic [3:0] ix;
    if (k < 8)                lit = g[7-k];
    else if (k == 8 && b_nine) lit = lg ? g[0] : 1'b0;
    else                      lit = 1'b0;
    if (b_blink && a[7] && off_phase()) lit = 1'b0;
    if (cur) lit = 1'b1;
    if (lit)          ix = a[3:0];
    else if (b_blink) ix = {1'b0, a[6:4]};
    else              ix = a[7:4];
    return b_pal[ix & b_mask];
  endfunction

  function automatic logic [5:0] exp_gfx(input logic [3:0] v);
    logic [3:0] ix;
    ix = v & b_mask;
    if (b_blink && off_phase() && ix >= 4'd8) ix = ix - 4'd8;
    return b_pal[ix];
  endfunction

  task automatic wr(input logic [4:0] a, input logic [5:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a < 5'd16) b_pal[a[3:0]] = d;
    else if (a == 5'd16) begin b_gfx = d[0]; b_nine = d[2]; b_blink = d[3]; end
    else if (a == 5'd17) b_mask = d[3:0];
  endtask

  task automatic text_char(input string tag, input logic [7:0] g, input logic [7:0] a,
                           input logic lg, input logic cur);
    int w;
    w = b_nine ? 9 : 8;
    @(negedge clk);
    load_strobe = 1'b1; glyph_in = g; attr_in = a; line_gfx = lg; cursor_in = cur;
    @(negedge clk);
    load_strobe = 1'b0; glyph_in = 8'($urandom); attr_in = 8'($urandom);
    for (int k = 0; k < w; k++) begin
      @(negedge clk);
      chk(tag, pix_out, exp_text(g, a, lg, cur, k));
    end
  endtask

  task automatic rand_chars(input string tag, input int n, input logic cur);
    for (int i = 0; i < n; i++)
      text_char(tag, 8'($urandom), 8'($urandom), 1'($urandom), cur);
  endtask

  task automatic vs_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); vsync = 1'b1;
      @(negedge clk); vsync = 1'b0;
      b_vs++;
    end
  endtask

  task automatic gfx_run(input string tag, input int n, input bit fixed, input logic [3:0] fv);
    logic [5:0] e1, e2;
    bit v1, v2;
    logic [3:0] val;
    v1 = 0; v2 = 0; e1 = '0; e2 = '0;
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      if (v2) chk(tag, pix_out, e2);
      e2 = e1; v2 = v1;
      if (i < n) begin
        val = fixed ? fv : 4'($urandom);
        attr_in = {4'($urandom), val};
        load_strobe = 1'($urandom);
        e1 = exp_gfx(val); v1 = 1;
      end else v1 = 0;
    end
    load_strobe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: pix_out=%0h expected=completion", pix_out);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [5:0] oldv, newv;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) b_pal[i] = '0;
    rst_n = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0; load_strobe = 0;
    glyph_in = '0; attr_in = '0; line_gfx = 0; cursor_in = 0; vsync = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", pix_out, 6'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", pix_out, 6'h00);
    rand_chars("R1 cleared palette and mask", 2, 1'b0);

    for (int i = 0; i < 16; i++) wr(5'(i), 6'($urandom));
    wr(5'd17, 6'h0F);

    // R3 R4: directed and random character cells
    text_char("R3 R4 directed cell", 8'hA5, 8'h1E, 1'b0, 1'b0);
    text_char("R4 blank glyph background", 8'h00, 8'hC3, 1'b0, 1'b0);
    rand_chars("R3 R4 random cells", 12, 1'b0);
    // R6: cursor forces foreground
    rand_chars("R6 cursor cells", 4, 1'b1);

    // R5: nine-dot cells
    wr(5'd16, 6'b000100);
    text_char("R5 line graphics dot 8", 8'h81, 8'h52, 1'b1, 1'b0);
    text_char("R5 ordinary dot 8", 8'h81, 8'h52, 1'b0, 1'b0);
    rand_chars("R5 random nine-dot cells", 6, 1'b0);

    // R7 R11: character blink
    wr(5'd16, 6'b001100);
    text_char("R7 on phase blinking cell", 8'hFF, 8'hB7, 1'b1, 1'b0);
    rand_chars("R4 R7 random blink cells", 4, 1'b0);
    vs_pulses(15);
    text_char("R11 still on after 15 edges", 8'hF0, 8'h9A, 1'b0, 1'b0);
    vs_pulses(1);
    text_char("R7 R11 off phase blinking cell", 8'hFF, 8'hB7, 1'b1, 1'b0);
    text_char("R7 off phase steady cell", 8'hFF, 8'h37, 1'b0, 1'b0);
    text_char("R6 cursor during off phase", 8'h3C, 8'hD5, 1'b0, 1'b1);
    rand_chars("R7 random off phase cells", 4, 1'b0);
    vs_pulses(16);
    text_char("R11 on again after 32 edges", 8'hFF, 8'hB7, 1'b0, 1'b0);

    // R10: plane mask in character mode
    wr(5'd17, 6'h05);
    rand_chars("R10 masked cells", 4, 1'b0);
    wr(5'd17, 6'h0F);

    // R8: graphics stream
    wr(5'd16, 6'b000001);
    gfx_run("R8 random pixels", 40, 1'b0, 4'h0);

    // R2: palette write latency
    @(negedge clk); attr_in = 8'h05;
    repeat (3) @(negedge clk);
    chk("R8 held pixel", pix_out, b_pal[5]);
    oldv = b_pal[5];
    newv = ~oldv;
    @(negedge clk); reg_we = 1'b1; reg_addr = 5'd5; reg_wdata = newv;
    @(negedge clk); reg_we = 1'b0;
    chk("R2 old entry at write edge", pix_out, oldv);
    @(negedge clk);
    chk("R2 new entry next pixel", pix_out, newv);
    b_pal[5] = newv;

    // R9: graphics blink
    wr(5'd16, 6'b001001);
    gfx_run("R9 on phase colour 12", 3, 1'b1, 4'd12);
    vs_pulses(16);
    gfx_run("R9 off phase colour 12", 3, 1'b1, 4'd12);
    gfx_run("R9 off phase colour 15", 3, 1'b1, 4'd15);
    gfx_run("R9 off phase colour 3", 3, 1'b1, 4'd3);
    gfx_run("R9 random off phase", 20, 1'b0, 4'h0);
    wr(5'd17, 6'h0B);
    gfx_run("R10 masked graphics", 20, 1'b0, 4'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule